// File: doc/BRIEF.md
# GPIO Controller with Interrupt Sensing

This block is a memory-mapped general-purpose I/O peripheral with up to 32 pins. Each pin can act as an output or as an input. As an output, the pin is driven from a stored output bit. As an input, the pin is brought through a two-stage synchronizer and is visible on register reads. Each pin also has its own interrupt detector. The detector can be set to sense an active-high level, an active-low level, a rising edge, a falling edge or any transition. Detected events are latched into a pending vector. That vector is masked by an enable vector and folded into one interrupt request line.

Software reaches the block through a single-cycle register port. The port takes a word address, a write strobe, write data, and read data that follows the address in the same cycle. Three per-pin configuration vectors together choose the trigger: a level-or-edge select, a polarity, and a both-transitions override. Pending bits are removed by writing ones to a separate clear word. A read-only version word reads 3, which tells software that the both-transitions override is present.

Word addresses are: 0 pin value, 1 direction, 2 interrupt enable, 3 masked status, 4 pending, 5 clear, 6 edge select, 7 polarity, 8 version, 9 both-transitions. Pin n is bit n of every word.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every direction bit is 1 (all pins are inputs), so pin_oe is all zeros. All interrupt enables are 0, irq is 0, the polarity word reads all ones and the edge-select word reads 0.
- R2: A direction bit of 0 makes that pin an output. Its pin_oe bit is then 1, and its pin_out bit equals the matching bit written to the value word (address 0).
- R3: A read of address 0 returns, for an input pin, the pin level as synchronized by two flip-flops, and for an output pin the stored output bit.
- R4: With edge select 0 (level mode), a polarity bit of 1 senses a high level and 0 senses a low level. The pending bit is set again on every cycle the level stays active, so a clear does not stick while the level holds.
- R5: With edge select 1 and both-transitions 0, polarity 1 senses only rising edges and polarity 0 senses only falling edges. A pin change made between clock edges first shows in the pending word after the third rising clock edge.
- R6: With edge select 1 and both-transitions 1, every transition sets the pending bit, whatever the polarity. With edge select 0, the both-transitions bit has no effect.
- R7: Writing a 1 to a bit of the clear word (address 5) clears that pending bit. Writing a 0 leaves it unchanged. If a new event for that pin arrives in the same cycle as the clear, the pending bit stays set.
- R8: irq is the OR over all pins of pending AND enable. The status word (address 3) reads pending AND enable.
- R9: The version word (address 8) always reads 3. Writes to the status, pending and version addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Write strobe, commits on the rising clock edge |
| reg_addr | input | 4 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, same cycle |
| pin_in | input | NPINS | Pin levels from the pads |
| pin_out | output | NPINS | Output levels to the pads |
| pin_oe | output | NPINS | Output enable per pin, 1 = drive |
| irq | output | 1 | Combined interrupt request |

## Verification
Two functions can fall in the same cycle: a software write to the clear word and a new detected event on the same pin. The bench sets this up on a pin in both-transitions mode. It already has a pending bit, and it is then given a second transition timed so that the clear write commits on exactly the edge where that event is latched. The pending bit must read 1 afterwards. A control case, where the clear has no event beside it, must read 0. Level-mode pins are checked the same way: a clear written while the level is still active must not remove the bit.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;
    localparam logic [DATA_W-1:0] VERSION_ID = 32'd3;

    typedef enum logic [ADDR_W-1:0] {
        RA_VAL  = 4'd0,
        RA_DIR  = 4'd1,
        RA_IEN  = 4'd2,
        RA_STAT = 4'd3,
        RA_PEND = 4'd4,
        RA_CLR  = 4'd5,
        RA_MODE = 4'd6,
        RA_POL  = 4'd7,
        RA_VER  = 4'd8,
        RA_BOTH = 4'd9
    } reg_idx_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = async_in;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.s2;
endmodule

// File: rtl/gpio_trig.sv
module gpio_trig #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] edge_sel,
    input  logic [W-1:0] pol,
    input  logic [W-1:0] both,
    output logic [W-1:0] evt
);
    logic [W-1:0] prev_d, prev_q;

    always_comb prev_d = cur;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar i = 0; i < W; i++) begin : g_pin
        logic rise, fall, edge_hit, level_hit;
        assign rise      = cur[i] & ~prev_q[i];
        assign fall      = ~cur[i] & prev_q[i];
        assign edge_hit  = both[i] ? (rise | fall) : (pol[i] ? rise : fall);
        assign level_hit = pol[i] ? cur[i] : ~cur[i];
        assign evt[i]    = edge_sel[i] ? edge_hit : level_hit;
    end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq
);
    typedef struct packed {
        logic [NPINS-1:0] val;
        logic [NPINS-1:0] dir;
        logic [NPINS-1:0] ien;
        logic [NPINS-1:0] mode;
        logic [NPINS-1:0] pol;
        logic [NPINS-1:0] both;
        logic [NPINS-1:0] pend;
    } regs_t;

    regs_t st_d, st_q;
    logic [NPINS-1:0] sync_in;
    logic [NPINS-1:0] evt;
    logic [NPINS-1:0] clr_mask;
    logic [NPINS-1:0] wbits;
    logic [NPINS-1:0] pin_now;
    logic [NPINS-1:0] masked;
    logic [NPINS-1:0] rd_bits;

    gpio_sync #(.W(NPINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(pin_in),
        .sync_out(sync_in)
    );

    gpio_trig #(.W(NPINS)) u_trig (
        .clk     (clk),
        .rst_n   (rst_n),
        .cur     (sync_in),
        .edge_sel(st_q.mode),
        .pol     (st_q.pol),
        .both    (st_q.both),
        .evt     (evt)
    );

    assign wbits   = reg_wdata[NPINS-1:0];
    assign pin_now = (st_q.dir & sync_in) | (~st_q.dir & st_q.val);
    assign masked  = st_q.pend & st_q.ien;

    always_comb begin
        st_d     = st_q;
        clr_mask = '0;
        if (reg_we) begin
            case (reg_idx_e'(reg_addr))
                RA_VAL:  st_d.val  = wbits;
                RA_DIR:  st_d.dir  = wbits;
                RA_IEN:  st_d.ien  = wbits;
                RA_CLR:  clr_mask  = wbits;
                RA_MODE: st_d.mode = wbits;
                RA_POL:  st_d.pol  = wbits;
                RA_BOTH: st_d.both = wbits;
                default: ;
            endcase
        end
        st_d.pend = (st_q.pend & ~clr_mask) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.dir  <= '1;
            st_q.pol  <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_bits = '0;
        case (reg_idx_e'(reg_addr))
            RA_VAL:  rd_bits = pin_now;
            RA_DIR:  rd_bits = st_q.dir;
            RA_IEN:  rd_bits = st_q.ien;
            RA_STAT: rd_bits = masked;
            RA_PEND: rd_bits = st_q.pend;
            RA_MODE: rd_bits = st_q.mode;
            RA_POL:  rd_bits = st_q.pol;
            RA_BOTH: rd_bits = st_q.both;
            default: rd_bits = '0;
        endcase
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_idx_e'(reg_addr) == RA_VER) reg_rdata = VERSION_ID;
        else                                 reg_rdata[NPINS-1:0] = rd_bits;
    end

    assign pin_out = st_q.val;
    assign pin_oe  = ~st_q.dir;
    assign irq     = |masked;
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [NPINS-1:0]  pin_oe,
    input logic              irq,
    input logic [NPINS-1:0]  ien,
    input logic [NPINS-1:0]  pend,
    input logic [NPINS-1:0]  evt
);
    assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == RA_DIR) |=> (pin_oe == ~$past(reg_wdata[NPINS-1:0])));

    // covers R4 and R5: every detected event is latched into pending
    assert_event_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((pend & $past(evt)) == $past(evt)));

    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == RA_CLR) |=>
            ((pend & $past(reg_wdata[NPINS-1:0]) & ~$past(evt)) == '0));

    assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ien == '0) |-> !irq);

    assert_version_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == RA_VER) |-> (reg_rdata == VERSION_ID));
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NPINS(NPINS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .pin_oe   (pin_oe),
    .irq      (irq),
    .ien      (st_q.ien),
    .pend     (st_q.pend),
    .evt      (evt)
);

// File: tb/sim_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_irq_ctrl;
    localparam int N = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = 4'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [N-1:0] pin_in = '0;
    logic [N-1:0] pin_out, pin_oe;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gpio_irq_ctrl #(.NPINS(N)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        pin_in = '0; reg_we = 1'b0;
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(4);
        wr(4'd5, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(4'd1, d); check("R1 dir reset", d, 32'hFFFF_FFFF);
        check("R1 oe reset", pin_oe, 32'h0);
        rd(4'd2, d); check("R1 enable reset", d, 32'h0);
        check("R1 irq reset", {31'b0, irq}, 32'h0);
        rd(4'd7, d); check("R1 polarity reset", d, 32'hFFFF_FFFF);
        rd(4'd6, d); check("R1 edge select reset", d, 32'h0);
        rd(4'd8, d); check("R9 version", d, 32'd3);
    endtask

    task automatic t_output();
        logic [31:0] d;
        do_reset();
        wr(4'd1, 32'hFFFF_0000);
        wr(4'd0, 32'h0000_A5A5);
        check("R2 oe", pin_oe, 32'h0000_FFFF);
        check("R2 out", pin_out & 32'h0000_FFFF, 32'h0000_A5A5);
        @(negedge clk) pin_in = 32'h1234_FFFF;
        idle(3);
        rd(4'd0, d); check("R3 value read mix", d, 32'h1234_A5A5);
        wr(4'd1, 32'hFFFF_FFFF);
        check("R2 oe back to input", pin_oe, 32'h0);
        idle(3);
        rd(4'd0, d); check("R3 value read inputs", d, 32'h1234_FFFF);
    endtask

    task automatic t_level();
        logic [31:0] d;
        do_reset();
        @(negedge clk) pin_in[3] = 1'b1;
        idle(5);
        rd(4'd4, d); check("R4 level high pend", d, 32'h8);
        wr(4'd5, 32'h8);
        rd(4'd4, d); check("R4 clear does not stick", d, 32'h8);
        @(negedge clk) pin_in[3] = 1'b0;
        idle(5);
        wr(4'd5, 32'h8);
        idle(1);
        rd(4'd4, d); check("R4 inactive after clear", d, 32'h0);
        wr(4'd7, 32'hFFFF_FFF7);
        idle(2);
        rd(4'd4, d); check("R4 active low pend", d, 32'h8);
    endtask

    task automatic t_edge();
        logic [31:0] d;
        do_reset();
        wr(4'd6, 32'hFFFF_FFFF);
        wr(4'd7, 32'hFFFF_FFBF);
        wr(4'd5, 32'hFFFF_FFFF);
        @(negedge clk) pin_in[5] = 1'b1;
        reg_addr = 4'd4;
        repeat (2) @(posedge clk);
        #1 check("R5 pend not before 3rd edge", reg_rdata, 32'h0);
        @(posedge clk);
        #1 check("R5 rise pend at 3rd edge", reg_rdata, 32'h20);
        wr(4'd5, 32'h20);
        @(negedge clk) pin_in[5] = 1'b0;
        idle(5);
        rd(4'd4, d); check("R5 fall ignored on rising pin", d, 32'h0);
        @(negedge clk) pin_in[6] = 1'b1;
        idle(5);
        rd(4'd4, d); check("R5 rise ignored on falling pin", d, 32'h0);
        @(negedge clk) pin_in[6] = 1'b0;
        idle(5);
        rd(4'd4, d); check("R5 fall pend", d, 32'h40);
    endtask

    task automatic t_both();
        logic [31:0] d;
        do_reset();
        wr(4'd6, 32'h0000_0080);
        wr(4'd9, 32'h0000_0180);
        wr(4'd7, 32'hFFFF_FF7F);
        @(negedge clk) pin_in[7] = 1'b1;
        idle(5);
        rd(4'd4, d); check("R6 rise pend", d, 32'h80);
        wr(4'd5, 32'h80);
        @(negedge clk) pin_in[7] = 1'b0;
        idle(5);
        rd(4'd4, d); check("R6 fall pend", d, 32'h80);
        wr(4'd5, 32'h80);
        @(negedge clk) pin_in[8] = 1'b1;
        idle(5);
        wr(4'd5, 32'h100);
        rd(4'd4, d); check("R6 level pin keeps level behavior", d, 32'h100);
        @(negedge clk) pin_in[8] = 1'b0;
        idle(5);
        wr(4'd5, 32'h100);
        idle(1);
        rd(4'd4, d); check("R6 level pin ignores falling", d, 32'h0);
    endtask

    task automatic t_clear();
        logic [31:0] d;
        do_reset();
        wr(4'd6, 32'hFFFF_FFFF);
        wr(4'd9, 32'h0000_1000);
        @(negedge clk) pin_in[11:10] = 2'b11;
        idle(5);
        rd(4'd4, d); check("R7 two pend", d, 32'hC00);
        wr(4'd5, 32'h400);
        rd(4'd4, d); check("R7 one cleared, zero bits kept", d, 32'h800);
        @(negedge clk) pin_in[12] = 1'b1;
        idle(5);
        rd(4'd4, d); check("R7 pin12 pend", d, 32'h1800);
        @(negedge clk) pin_in[12] = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 4'd5; reg_wdata = 32'h1000;
        @(negedge clk) reg_we = 1'b0;
        rd(4'd4, d); check("R7 event wins over clear", d, 32'h1800);
        wr(4'd5, 32'h1000);
        rd(4'd4, d); check("R7 clear without event", d, 32'h800);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        check("R8 irq masked", {31'b0, irq}, 32'h0);
        rd(4'd3, d); check("R8 status masked", d, 32'h0);
        wr(4'd2, 32'h800);
        check("R8 irq on", {31'b0, irq}, 32'h1);
        rd(4'd3, d); check("R8 status", d, 32'h800);
        wr(4'd4, 32'h0);
        wr(4'd3, 32'h0);
        wr(4'd8, 32'h0);
        rd(4'd4, d); check("R9 pend write ignored", d, 32'h800);
        rd(4'd8, d); check("R9 version write ignored", d, 32'd3);
        wr(4'd2, 32'h400);
        check("R8 other enable", {31'b0, irq}, 32'h0);
        wr(4'd2, 32'h800);
        wr(4'd5, 32'h800);
        check("R8 irq after clear", {31'b0, irq}, 32'h0);
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_output();
        t_level();
        t_edge();
        t_both();
        t_clear();
        t_irq();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule